// File: doc/BRIEF.md
# Calendar Clock Core

This block keeps wall-clock time as seven binary fields: seconds, minutes, hours, day of week, date, month and a two-digit year. An internal prescaler counts pulses of an input clock enable. After a set number of pulses it issues a one-second tick, and each tick advances the calendar by one second. Seconds carry into minutes, minutes into hours, and hours into the day fields. Month lengths and a simple leap-year rule decide when the date carries into the month and the month into the year.

Software uses a small register bus. It can read any field with one cycle of latency, and it can change any field. A field write only counts if the write just before it went to the unlock register. An accepted write does not show at once: it waits as a pending value and takes effect on the next one-second tick. A control bit restarts the prescaler, so the next tick comes a full second after the restart.

Top module: `cal_clock_core`

## Requirements
- R1: After reset, the fields read seconds 0, minutes 0, hours 0, day of week 1, date 1, month 1 and year 0.
- R2: The prescaler issues one tick for every TICK_DIV cycles with `tick_en` high. Each tick raises seconds by one and pulses `sec_tick` for one cycle.
- R3: Seconds and minutes go from 59 to 0 and carry into the next field. Hours go from 23 to 0 and carry into date and day of week.
- R4: Day of week counts 1 to 7, where 1 is Sunday, and goes from 7 back to 1 when the day carries.
- R5: Months 4, 6, 9 and 11 end after date 30. All other months except 2 end after date 31. At the end of a month the date returns to 1.
- R6: February ends after date 29 when the year value is divisible by 4, year 0 included. Otherwise it ends after date 28.
- R7: When month 12 ends, the month returns to 1 and the year rises by one. Year 99 wraps to 0.
- R8: A write to a field address (0 to 6) is accepted only if the bus write just before it went to the unlock address 7. Any other write is ignored. A bus write to any address other than 7 clears the unlock.
- R9: An accepted write stays pending until the next tick and is applied on that tick. Until then, reads return the old committed value.
- R10: When a pending write and a carry land on the same tick, the written field takes the written value and the other fields advance normally.
- R11: A write to address 8 with data bit 0 set clears the prescaler. The next tick then comes only after a full TICK_DIV enables.
- R12: Read addresses are 0 seconds, 1 minutes, 2 hours, 3 day of week, 4 date, 5 month and 6 year. `rdata` shows the value one clock after a cycle with `rd_en` high. Any other address reads as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_en | input | 1 | Clock enable counted by the prescaler |
| wr_en | input | 1 | Bus write strobe |
| rd_en | input | 1 | Bus read strobe |
| addr | input | 4 | Bus register address |
| wdata | input | 8 | Bus write data |
| rdata | output | 8 | Read data, registered |
| sec_tick | output | 1 | One-cycle pulse on each one-second tick |

## Verification
Plain counting from reset shows the seconds step. Preset times just before each boundary then test the carry chain one case at a time. Each preset is chosen so that only one rule can explain the result:
- a 30-day month and a 31-day month;
- February in year 4, year 5 and year 0, which separates the leap rule from a plain 28-day February;
- the end of year 99, which drives every field across its wrap at once.

Other tests cover the write rules:
- Writes with no unlock, and writes whose unlock was used up by a control write, must leave the time unchanged.
- A read taken between an accepted write and the next tick shows that the write is held back until that tick.
- A pending hour write that lands on a minute carry shows which value wins.

The restart test counts enables across a prescaler clear. Counting from zero gives a different tick time than keeping the old count.

// File: rtl/cal_pkg.sv
`timescale 1ns/1ps
package cal_pkg;
  localparam int NF = 7;
  localparam int DW = 8;
  localparam int AW = 4;

  localparam int F_SEC  = 0;
  localparam int F_MIN  = 1;
  localparam int F_HR   = 2;
  localparam int F_DOW  = 3;
  localparam int F_DATE = 4;
  localparam int F_MON  = 5;
  localparam int F_YR   = 6;

  localparam logic [AW-1:0] ADDR_UNLOCK = 4'd7;
  localparam logic [AW-1:0] ADDR_CTRL   = 4'd8;

  typedef logic [NF-1:0][DW-1:0] fields_t;

  function automatic logic [DW-1:0] field_mask(input int idx);
    case (idx)
      F_SEC, F_MIN: return 8'h3F;
      F_HR, F_DATE: return 8'h1F;
      F_DOW:        return 8'h07;
      F_MON:        return 8'h0F;
      default:      return 8'h7F;
    endcase
  endfunction

  function automatic logic [DW-1:0] month_len(input logic [DW-1:0] mon,
                                              input logic [DW-1:0] yr);
    case (mon)
      8'd2:                      return (yr[1:0] == 2'b00) ? 8'd29 : 8'd28;
      8'd4, 8'd6, 8'd9, 8'd11:   return 8'd30;
      default:                   return 8'd31;
    endcase
  endfunction
endpackage

// File: rtl/cal_prescaler.sv
`timescale 1ns/1ps
module cal_prescaler #(
  parameter int TICK_DIV = 32768
) (
  input  logic clk,
  input  logic rst_ni,
  input  logic tick_en,
  input  logic restart,
  output logic sec_tick
);
  localparam int CW = (TICK_DIV > 2) ? $clog2(TICK_DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(TICK_DIV - 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          tick_q, tick_d;

  always_comb begin
    cnt_d  = cnt_q;
    tick_d = 1'b0;
    if (restart) begin
      cnt_d = '0;
    end else if (tick_en) begin
      if (cnt_q == LAST) begin
        cnt_d  = '0;
        tick_d = 1'b1;
      end else begin
        cnt_d = cnt_q + CW'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      tick_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      tick_q <= tick_d;
    end
  end

  assign sec_tick = tick_q;

  AST_TICK_AT_WRAP: assert property (@(posedge clk) disable iff (!rst_ni)
    tick_q |-> (cnt_q == '0)); // R2
  AST_RESTART_CLEARS: assert property (@(posedge clk) disable iff (!rst_ni)
    restart |=> (cnt_q == '0) && !tick_q); // R11
endmodule

// File: rtl/cal_wr_gate.sv
`timescale 1ns/1ps
module cal_wr_gate
  import cal_pkg::*;
(
  input  logic          clk,
  input  logic          rst_ni,
  input  logic          wr_en,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  input  logic          sec_tick,
  output logic          restart,
  output logic [NF-1:0] pend_mask,
  output fields_t       pend_val
);
  logic          unl_q, unl_d;
  logic          accept;
  logic [NF-1:0] mask_q, mask_d;
  fields_t       val_q, val_d;

  assign accept  = wr_en && unl_q && (addr < AW'(NF));
  assign restart = wr_en && (addr == ADDR_CTRL) && wdata[0];

  always_comb begin
    unl_d = unl_q;
    if (wr_en) unl_d = (addr == ADDR_UNLOCK);
  end

  for (genvar g = 0; g < NF; g++) begin : g_pend
    always_comb begin
      mask_d[g] = sec_tick ? 1'b0 : mask_q[g];
      val_d[g]  = val_q[g];
      if (accept && (addr == AW'(g))) begin
        mask_d[g] = 1'b1;
        val_d[g]  = wdata & field_mask(g);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      unl_q  <= 1'b0;
      mask_q <= '0;
      val_q  <= '0;
    end else begin
      unl_q  <= unl_d;
      mask_q <= mask_d;
      val_q  <= val_d;
    end
  end

  assign pend_mask = mask_q;
  assign pend_val  = val_q;

  AST_LOCKED_WR_IGNORED: assert property (@(posedge clk) disable iff (!rst_ni)
    (wr_en && !unl_q && !sec_tick) |=> $stable(mask_q)); // R8
  AST_UNLOCK_CONSUMED: assert property (@(posedge clk) disable iff (!rst_ni)
    (wr_en && (addr != ADDR_UNLOCK)) |=> !unl_q); // R8
  AST_PEND_CLEARED: assert property (@(posedge clk) disable iff (!rst_ni)
    (sec_tick && !wr_en) |=> (mask_q == '0)); // R9
endmodule

// File: rtl/cal_counter.sv
`timescale 1ns/1ps
module cal_counter
  import cal_pkg::*;
(
  input  logic          clk,
  input  logic          rst_ni,
  input  logic          sec_tick,
  input  logic [NF-1:0] pend_mask,
  input  fields_t       pend_val,
  output fields_t       fields
);
  fields_t fld_q, fld_d, adv;
  logic c_min, c_hr, c_day, c_mon, c_yr;

  always_comb begin
    adv   = fld_q;
    c_min = 1'b0;
    c_hr  = 1'b0;
    c_day = 1'b0;
    c_mon = 1'b0;
    c_yr  = 1'b0;
    if (fld_q[F_SEC] >= 8'd59) begin
      adv[F_SEC] = '0;
      c_min      = 1'b1;
    end else begin
      adv[F_SEC] = fld_q[F_SEC] + 8'd1;
    end
    if (c_min) begin
      if (fld_q[F_MIN] >= 8'd59) begin
        adv[F_MIN] = '0;
        c_hr       = 1'b1;
      end else begin
        adv[F_MIN] = fld_q[F_MIN] + 8'd1;
      end
    end
    if (c_hr) begin
      if (fld_q[F_HR] >= 8'd23) begin
        adv[F_HR] = '0;
        c_day     = 1'b1;
      end else begin
        adv[F_HR] = fld_q[F_HR] + 8'd1;
      end
    end
    if (c_day) begin
      adv[F_DOW] = (fld_q[F_DOW] >= 8'd7) ? 8'd1 : fld_q[F_DOW] + 8'd1;
      if (fld_q[F_DATE] >= month_len(fld_q[F_MON], fld_q[F_YR])) begin
        adv[F_DATE] = 8'd1;
        c_mon       = 1'b1;
      end else begin
        adv[F_DATE] = fld_q[F_DATE] + 8'd1;
      end
    end
    if (c_mon) begin
      if (fld_q[F_MON] >= 8'd12) begin
        adv[F_MON] = 8'd1;
        c_yr       = 1'b1;
      end else begin
        adv[F_MON] = fld_q[F_MON] + 8'd1;
      end
    end
    if (c_yr) begin
      adv[F_YR] = (fld_q[F_YR] >= 8'd99) ? 8'd0 : fld_q[F_YR] + 8'd1;
    end
  end

  for (genvar g = 0; g < NF; g++) begin : g_next
    always_comb begin
      fld_d[g] = fld_q[g];
      if (sec_tick) fld_d[g] = pend_mask[g] ? pend_val[g] : adv[g];
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      fld_q         <= '0;
      fld_q[F_DOW]  <= 8'd1;
      fld_q[F_DATE] <= 8'd1;
      fld_q[F_MON]  <= 8'd1;
    end else begin
      fld_q <= fld_d;
    end
  end

  assign fields = fld_q;

  AST_HOLD_NO_TICK: assert property (@(posedge clk) disable iff (!rst_ni)
    !sec_tick |=> $stable(fld_q)); // R9
  AST_SEC_STEP: assert property (@(posedge clk) disable iff (!rst_ni)
    (sec_tick && !pend_mask[F_SEC] && (fld_q[F_SEC] < 8'd59))
      |=> (fld_q[F_SEC] == $past(fld_q[F_SEC]) + 8'd1)); // R2
  AST_PEND_WINS: assert property (@(posedge clk) disable iff (!rst_ni)
    (sec_tick && pend_mask[F_HR]) |=> (fld_q[F_HR] == $past(pend_val[F_HR]))); // R10
  AST_DOW_RANGE: assert property (@(posedge clk) disable iff (!rst_ni)
    (sec_tick && !pend_mask[F_DOW] && (fld_q[F_DOW] == 8'd7) && c_day)
      |=> (fld_q[F_DOW] == 8'd1)); // R4
endmodule

// File: rtl/cal_clock_core.sv
`timescale 1ns/1ps
module cal_clock_core
  import cal_pkg::*;
#(
  parameter int TICK_DIV = 32768
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick_en,
  input  logic          wr_en,
  input  logic          rd_en,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata,
  output logic          sec_tick
);
  logic          rst_s1, rst_s2;
  logic          restart;
  logic [NF-1:0] pend_mask;
  fields_t       pend_val, fields;
  logic [DW-1:0] rdata_q, rdata_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s1 <= 1'b0;
      rst_s2 <= 1'b0;
    end else begin
      rst_s1 <= 1'b1;
      rst_s2 <= rst_s1;
    end
  end

  cal_prescaler #(.TICK_DIV(TICK_DIV)) u_pre (
    .clk(clk), .rst_ni(rst_s2), .tick_en(tick_en),
    .restart(restart), .sec_tick(sec_tick)
  );

  cal_wr_gate u_gate (
    .clk(clk), .rst_ni(rst_s2), .wr_en(wr_en), .addr(addr),
    .wdata(wdata), .sec_tick(sec_tick), .restart(restart),
    .pend_mask(pend_mask), .pend_val(pend_val)
  );

  cal_counter u_cnt (
    .clk(clk), .rst_ni(rst_s2), .sec_tick(sec_tick),
    .pend_mask(pend_mask), .pend_val(pend_val), .fields(fields)
  );

  always_comb begin
    rdata_d = rdata_q;
    if (rd_en) rdata_d = (addr < AW'(NF)) ? fields[addr[2:0]] : '0;
  end

  always_ff @(posedge clk or negedge rst_s2) begin
    if (!rst_s2) rdata_q <= '0;
    else         rdata_q <= rdata_d;
  end

  assign rdata = rdata_q;

  AST_READ_HOLD: assert property (@(posedge clk) disable iff (!rst_s2)
    !rd_en |=> $stable(rdata_q)); // R12
endmodule

// File: tb/sim_cal_clock_core.sv
`timescale 1ns/1ps
module sim_cal_clock_core;
  localparam int DIV = 4;
  logic clk = 1'b0;
  logic rst_n, tick_en, wr_en, rd_en;
  logic [3:0] addr;
  logic [7:0] wdata, rdata;
  logic sec_tick;
  int checks = 0, errors = 0, cycles = 0;

  always #2 clk = ~clk;

  cal_clock_core #(.TICK_DIV(DIV)) u0 (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .wr_en(wr_en),
    .rd_en(rd_en), .addr(addr), .wdata(wdata), .rdata(rdata),
    .sec_tick(sec_tick)
  );

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      errors++; checks++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic check(input string req, input int got, input int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, got, exp);
    end
  endtask

  task automatic bus_write(input int a, input int d);
    @(negedge clk); wr_en = 1'b1; addr = 4'(a); wdata = 8'(d);
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic bus_read(input int a, output int d);
    @(negedge clk); rd_en = 1'b1; addr = 4'(a);
    @(negedge clk); rd_en = 1'b0; d = int'(rdata);
  endtask

  task automatic expect_field(input string req, input int a, input int exp);
    int v;
    bus_read(a, v);
    check(req, v, exp);
  endtask

  task automatic pulses(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); tick_en = 1'b1;
    end
    @(negedge clk); tick_en = 1'b0;
    @(negedge clk);
  endtask

  task automatic seconds(input int n);
    pulses(n * DIV);
  endtask

  task automatic set_field(input int a, input int v);
    bus_write(7, 0);
    bus_write(a, v);
  endtask

  task automatic set_time(input int s, input int mi, input int h,
                          input int dt, input int mo, input int y);
    set_field(0, s); set_field(1, mi); set_field(2, h);
    set_field(4, dt); set_field(5, mo); set_field(6, y);
    seconds(1);
  endtask

  task automatic t_reset();
    expect_field("R1 sec", 0, 0);
    expect_field("R1 min", 1, 0);
    expect_field("R1 hr", 2, 0);
    expect_field("R1 dow", 3, 1);
    expect_field("R1 date", 4, 1);
    expect_field("R1 mon", 5, 1);
    expect_field("R1 yr", 6, 0);
    expect_field("R12 unmapped", 9, 0);
  endtask

  task automatic t_count();
    seconds(3);
    expect_field("R2 sec after 3", 0, 3);
    expect_field("R2 min", 1, 0);
  endtask

  task automatic t_pending();
    set_field(0, 58);
    expect_field("R9 committed before tick", 0, 3);
    seconds(1);
    expect_field("R9 applied", 0, 58);
    seconds(2);
    expect_field("R3 sec wrap", 0, 0);
    expect_field("R3 min carry", 1, 1);
  endtask

  task automatic t_locked();
    bus_write(1, 30);
    seconds(1);
    expect_field("R8 no unlock", 1, 1);
    bus_write(7, 0);
    bus_write(8, 0);
    bus_write(1, 40);
    seconds(1);
    expect_field("R8 unlock consumed", 1, 1);
  endtask

  task automatic t_year_wrap();
    set_field(3, 7);
    set_time(59, 59, 23, 31, 12, 99);
    seconds(1);
    expect_field("R3 hr wrap", 2, 0);
    expect_field("R3 min wrap", 1, 0);
    expect_field("R4 dow 7 to 1", 3, 1);
    expect_field("R5 date to 1", 4, 1);
    expect_field("R7 mon to 1", 5, 1);
    expect_field("R7 yr 99 to 0", 6, 0);
  endtask

  task automatic t_feb();
    set_time(59, 59, 23, 28, 2, 4);
    seconds(1);
    expect_field("R6 leap yr4 date", 4, 29);
    expect_field("R6 leap yr4 mon", 5, 2);
    set_time(59, 59, 23, 28, 2, 5);
    seconds(1);
    expect_field("R6 yr5 date", 4, 1);
    expect_field("R6 yr5 mon", 5, 3);
    set_time(59, 59, 23, 28, 2, 0);
    seconds(1);
    expect_field("R6 leap yr0 date", 4, 29);
  endtask

  task automatic t_months();
    set_time(59, 59, 23, 30, 4, 7);
    seconds(1);
    expect_field("R5 apr end date", 4, 1);
    expect_field("R5 apr end mon", 5, 5);
    set_time(59, 59, 23, 30, 1, 7);
    seconds(1);
    expect_field("R5 jan 31", 4, 31);
    expect_field("R5 jan mon", 5, 1);
  endtask

  task automatic t_same_tick();
    set_time(59, 59, 3, 10, 6, 7);
    set_field(2, 5);
    seconds(1);
    expect_field("R10 written hr", 2, 5);
    expect_field("R10 min advances", 1, 0);
    expect_field("R10 sec advances", 0, 0);
    expect_field("R10 date kept", 4, 10);
  endtask

  task automatic t_restart();
    int s0;
    bus_read(0, s0);
    pulses(2);
    bus_write(8, 1);
    pulses(DIV - 1);
    expect_field("R11 no early tick", 0, s0);
    pulses(1);
    expect_field("R11 tick after full div", 0, s0 + 1);
  endtask

  initial begin
    rst_n = 1'b0; tick_en = 1'b0; wr_en = 1'b0; rd_en = 1'b0;
    addr = '0; wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_reset();
    t_count();
    t_pending();
    t_locked();
    t_year_wrap();
    t_feb();
    t_months();
    t_same_tick();
    t_restart();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule